// File: doc/BRIEF.md
# Counter User-Enable Register with Access Trap Routing

This block holds the user-enable control for a bank of activity counters and screens every coprocessor-style access aimed at that control. For each request it looks at the current privilege level and at the trap controls supplied by the hypervisor and secure-monitor levels. It then either completes the access or reports a trap, which gives the level that must handle it, the style of trap and a syndrome class.

The stored enable is also exported as a level signal. A neighbouring counter block uses it to decide whether level-0 software may touch the counters themselves. The enable never governs access to this register itself. Exception entry is left to the consumer of the trap outputs. All outputs are combinational and valid in the request cycle. A completed write takes effect at the clock edge that ends that cycle.

Top module: `ctr_user_gate`

## Requirements
- R1: A request is recognised only when coprocessor=15, op1=0, crn=13, crm=2 and op2=3. Any other request raises no trap, returns zero read data and leaves the stored enable unchanged.
- R2: Only write-data bit 0 is stored. Read data carries the enable in bit 0, and bits 31:1 always read as zero whatever was written.
- R3: After reset the enable is 0, no trap is signalled and read data is zero.
- R4: At level 0, when the hypervisor is enabled in the wide state, its register-group trap bit is set and the host-mode pair is not 2'b11, the access traps to level 2 in system-access style (style output 0). With the host-mode pair at 2'b11 this check does not fire.
- R5: At levels 0 and 1, when the hypervisor is enabled in the narrow state and its register-group trap bit is set, the access traps to level 2 in hypervisor style (style output 1).
- R6: At levels 0 and 1, if no earlier check fired, the hypervisor counter-access trap (enabled, wide state) routes to level 2. Otherwise, if level 3 is present in the wide state with its counter-access trap bit set, the access routes to level 3. When both are set, level 2 wins.
- R7: At level 1 the first check ignores the host-mode pair and fires even when it is 2'b11.
- R8: At level 2 only the level-3 counter-access trap applies. At level 3 every access completes.
- R9: Every trap reports class 0x03 with trap level 2 or 3. The trap strobe is high only in a cycle with a valid recognised request.
- R10: A trapped write leaves the stored enable unchanged. A trapped read returns zero data.
- R11: The enable output follows the stored bit. A level-0 read completes when no trap check fires, even with the enable at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cp | input | 4 | Coprocessor number |
| req_op1 | input | 3 | First opcode field |
| req_crn | input | 4 | Primary register field |
| req_crm | input | 4 | Secondary register field |
| req_op2 | input | 3 | Second opcode field |
| req_wdata | input | 32 | Write data |
| cur_level | input | 2 | Current privilege level 0..3 |
| hyp_on | input | 1 | Hypervisor level enabled |
| hyp_wide | input | 1 | Hypervisor in wide execution state |
| hyp_grp_trap | input | 1 | Hypervisor register-group trap bit |
| hyp_cnt_trap | input | 1 | Hypervisor counter-access trap bit |
| hyp_host | input | 2 | Hypervisor host-mode pair |
| mon_present | input | 1 | Level 3 implemented |
| mon_wide | input | 1 | Level 3 in wide execution state |
| mon_cnt_trap | input | 1 | Monitor counter-access trap bit |
| rd_data | output | 32 | Read data of a completed read |
| trap_valid | output | 1 | Trap strobe in the request cycle |
| trap_level | output | 2 | Level taking the trap |
| trap_hyp_style | output | 1 | 1 = hypervisor-style trap, 0 = system-access style |
| trap_class | output | 6 | Syndrome class |
| user_en | output | 1 | Stored enable for the counter block |

## Verification
The priority chain is exercised with one trap control at a time, then with pairs that overlap, such as hypervisor and monitor counter traps together, or the host-mode pair at 2'b11 combined with the counter trap. These pairs separate a wrong order from a missing check. Each level is driven with the same control settings, so a chain copied to the wrong level shows up. Near-miss encodings and all-ones write data separate full decode and bit masking from partial decode. Trapped reads and writes made with the enable at 1 show whether a trap truly blocks data.

// File: rtl/ctr_user_gate.sv
module ctr_user_gate (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [3:0]  req_cp,
  input  logic [2:0]  req_op1,
  input  logic [3:0]  req_crn,
  input  logic [3:0]  req_crm,
  input  logic [2:0]  req_op2,
  input  logic [31:0] req_wdata,
  input  logic [1:0]  cur_level,
  input  logic        hyp_on,
  input  logic        hyp_wide,
  input  logic        hyp_grp_trap,
  input  logic        hyp_cnt_trap,
  input  logic [1:0]  hyp_host,
  input  logic        mon_present,
  input  logic        mon_wide,
  input  logic        mon_cnt_trap,
  output logic [31:0] rd_data,
  output logic        trap_valid,
  output logic [1:0]  trap_level,
  output logic        trap_hyp_style,
  output logic [5:0]  trap_class,
  output logic        user_en
);
  localparam logic [5:0] TRAP_CLASS = 6'h03;

  logic hit, en_q;
  logic chk_grp_wide, chk_grp_narrow, chk_hyp_cnt, chk_mon_cnt;
  logic fire;
  logic [1:0] lvl;
  logic style;

  assign hit = req_cp == 4'd15 && req_op1 == 3'd0 && req_crn == 4'd13 &&
               req_crm == 4'd2 && req_op2 == 3'd3;

  assign chk_grp_wide   = hyp_on && hyp_wide && hyp_grp_trap &&
                          (cur_level == 2'd1 || hyp_host != 2'b11);
  assign chk_grp_narrow = hyp_on && !hyp_wide && hyp_grp_trap;
  assign chk_hyp_cnt    = hyp_on && hyp_wide && hyp_cnt_trap;
  assign chk_mon_cnt    = mon_present && mon_wide && mon_cnt_trap;

  always_comb begin
    fire  = 1'b0;
    lvl   = 2'd0;
    style = 1'b0;
    unique case (cur_level)
      2'd0, 2'd1: begin
        if (chk_grp_wide) begin
          fire = 1'b1; lvl = 2'd2;
        end else if (chk_grp_narrow) begin
          fire = 1'b1; lvl = 2'd2; style = 1'b1;
        end else if (chk_hyp_cnt) begin
          fire = 1'b1; lvl = 2'd2;
        end else if (chk_mon_cnt) begin
          fire = 1'b1; lvl = 2'd3;
        end
      end
      2'd2: begin
        if (chk_mon_cnt) begin
          fire = 1'b1; lvl = 2'd3;
        end
      end
      default: ;
    endcase
  end

  assign trap_valid     = req_valid && hit && fire;
  assign trap_level     = trap_valid ? lvl : 2'd0;
  assign trap_hyp_style = trap_valid && style;
  assign trap_class     = trap_valid ? TRAP_CLASS : 6'h00;
  assign rd_data        = (req_valid && hit && !req_write && !fire) ? {31'd0, en_q} : 32'd0;
  assign user_en        = en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else if (req_valid && req_write && hit && !fire) en_q <= req_wdata[0];
  end

  assert_miss_keeps_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !hit) |=> $stable(user_en));
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && hit && !trap_valid) |=> user_en == $past(req_wdata[0]));
  assert_high_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[31:1] == 31'd0);
  assert_top_level_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cur_level == 2'd3) |-> !trap_valid);
  assert_mon_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && trap_level == 2'd3) |-> (mon_cnt_trap && !hyp_cnt_trap || cur_level == 2'd2 || !hyp_on || !hyp_wide));
  assert_strobe_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> (req_valid && trap_class == 6'h03 && trap_level[1]));
  assert_trapped_write_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && trap_valid) |=> $stable(user_en));
  assert_trapped_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> rd_data == 32'd0);
endmodule

// File: tb/ctr_user_gate_tb.sv
module ctr_user_gate_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_write = 0;
  logic [3:0] req_cp = 4'd15, req_crn = 4'd13, req_crm = 4'd2;
  logic [2:0] req_op1 = 3'd0, req_op2 = 3'd3;
  logic [31:0] req_wdata = 0;
  logic [1:0] cur_level = 0;
  logic hyp_on = 0, hyp_wide = 0, hyp_grp_trap = 0, hyp_cnt_trap = 0;
  logic [1:0] hyp_host = 0;
  logic mon_present = 0, mon_wide = 0, mon_cnt_trap = 0;
  logic [31:0] rd_data;
  logic trap_valid, trap_hyp_style, user_en;
  logic [1:0] trap_level;
  logic [5:0] trap_class;

  int checks = 0, fails = 0;
  logic [31:0] s_rd;
  logic s_trap, s_style;
  logic [1:0] s_lvl;
  logic [5:0] s_cls;

  always #5 clk = ~clk;

  ctr_user_gate dut_i (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_ctl(input bit hon, input bit hw, input bit hg, input bit hc, input logic [1:0] host,
                         input bit mp, input bit mw, input bit mc);
    hyp_on = hon; hyp_wide = hw; hyp_grp_trap = hg; hyp_cnt_trap = hc; hyp_host = host;
    mon_present = mp; mon_wide = mw; mon_cnt_trap = mc;
  endtask

  task automatic access(input bit wr, input logic [1:0] lvl, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = wr; cur_level = lvl; req_wdata = d;
    #2;
    s_rd = rd_data; s_trap = trap_valid; s_lvl = trap_level; s_style = trap_hyp_style; s_cls = trap_class;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    #1;
  endtask

  task automatic expect_trap(input string req, input logic [1:0] lvl, input bit style);
    check(s_trap == 1, req, s_trap, 1);
    check(s_lvl == lvl, req, s_lvl, lvl);
    check(s_style == style, req, s_style, style);
    check(s_cls == 6'h03, {req, " R9 class"}, s_cls, 6'h03);
  endtask

  task automatic t_reset;
    check(user_en == 0, "R3 enable", user_en, 0);
    check(trap_valid == 0 && rd_data == 0, "R3 outputs", {trap_valid, rd_data[30:0]}, 0);
    access(0, 2'd0, 0);
    check(s_rd == 0 && !s_trap, "R11 read with enable 0", s_rd, 0);
  endtask

  task automatic t_readwrite;
    set_ctl(0,0,0,0,0,0,0,0);
    access(1, 2'd1, 32'hFFFF_FFFF);
    check(user_en == 1, "R11 enable out", user_en, 1);
    access(0, 2'd0, 0);
    check(s_rd == 32'd1, "R2 read masks high bits", s_rd, 1);
    access(1, 2'd3, 32'hFFFF_FFFE);
    check(user_en == 0, "R2 only bit0 stored", user_en, 0);
    access(1, 2'd0, 32'h1);
    check(user_en == 1, "R11 level0 write completes", user_en, 1);
  endtask

  task automatic t_decode;
    set_ctl(1,1,1,1,0,1,1,1);
    req_crm = 4'd3;
    access(1, 2'd0, 0);
    check(!s_trap && user_en == 1, "R1 crm miss", {s_trap, user_en}, 2'b01);
    req_crm = 4'd2; req_cp = 4'd14;
    access(0, 2'd0, 0);
    check(!s_trap && s_rd == 0, "R1 cp miss read", s_rd, 0);
    req_cp = 4'd15; req_op2 = 3'd2;
    set_ctl(0,0,0,0,0,0,0,0);
    access(1, 2'd1, 0);
    check(user_en == 1, "R1 op2 miss write", user_en, 1);
    req_op2 = 3'd3;
  endtask

  task automatic t_level0_host;
    set_ctl(1,1,1,0,2'b00,0,0,0);
    access(1, 2'd0, 0);
    expect_trap("R4 host 00", 2'd2, 0);
    check(user_en == 1, "R10 trapped write", user_en, 1);
    access(0, 2'd0, 0);
    check(s_rd == 0, "R10 trapped read zero", s_rd, 0);
    set_ctl(1,1,1,0,2'b11,0,0,0);
    access(0, 2'd0, 0);
    check(!s_trap && s_rd == 1, "R4 host 11 skips", s_rd, 1);
    set_ctl(1,1,1,1,2'b11,0,0,0);
    access(0, 2'd0, 0);
    expect_trap("R6 host 11 falls to counter trap", 2'd2, 0);
  endtask

  task automatic t_level1;
    set_ctl(1,1,1,0,2'b11,0,0,0);
    access(1, 2'd1, 0);
    expect_trap("R7 level1 ignores host", 2'd2, 0);
    check(user_en == 1, "R10 level1 trapped write", user_en, 1);
  endtask

  task automatic t_narrow;
    set_ctl(1,0,1,1,2'b00,0,0,0);
    access(0, 2'd0, 0);
    expect_trap("R5 narrow level0", 2'd2, 1);
    access(0, 2'd1, 0);
    expect_trap("R5 narrow level1", 2'd2, 1);
    set_ctl(1,0,0,1,2'b00,0,0,0);
    access(0, 2'd0, 0);
    check(!s_trap, "R6 narrow counter bit ignored", s_trap, 0);
  endtask

  task automatic t_counters;
    set_ctl(1,1,0,1,0,0,0,0);
    access(0, 2'd1, 0);
    expect_trap("R6 hyp counter", 2'd2, 0);
    set_ctl(0,1,0,1,0,1,1,1);
    access(0, 2'd0, 0);
    expect_trap("R6 monitor counter", 2'd3, 0);
    set_ctl(1,1,0,1,0,1,1,1);
    access(0, 2'd0, 0);
    expect_trap("R6 hyp beats monitor", 2'd2, 0);
    set_ctl(0,0,0,0,0,1,0,1);
    access(0, 2'd0, 0);
    check(!s_trap, "R6 narrow monitor ignored", s_trap, 0);
  endtask

  task automatic t_upper;
    set_ctl(1,1,1,1,2'b00,0,0,0);
    access(1, 2'd2, 0);
    check(!s_trap && user_en == 0, "R8 level2 ignores hyp", {s_trap, user_en}, 0);
    set_ctl(1,1,1,1,2'b00,1,1,1);
    access(1, 2'd2, 1);
    expect_trap("R8 level2 monitor", 2'd3, 0);
    check(user_en == 0, "R10 level2 trapped write", user_en, 0);
    access(1, 2'd3, 1);
    check(!s_trap && user_en == 1, "R8 level3 completes", {s_trap, user_en}, 2'b01);
  endtask

  initial begin
    bit timed_out;
    timed_out = 0;
    fork
      begin
        #25 rst_n = 1;
        t_reset; t_readwrite; t_decode; t_level0_host; t_level1; t_narrow; t_counters; t_upper;
      end
      begin
        #100000 timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) check(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule